// File: doc/BRIEF.md
# Serial Channel Mode Register and Start Control

This block keeps the 16-bit mode word of one channel in a multi-protocol serial unit and decodes it into the control signals the rest of the channel uses. From the word it picks one of two prescaled operation-clock enables. It then makes a transfer-clock enable, either by dividing that operation clock or by passing through an external serial-clock enable. It also presents the protocol mode, the interrupt-source choice and a receive-data path with optional inversion.

The block also controls when a transfer starts. In software-trigger mode a start strobe on a running channel gives a one-clock start pulse. In receive-edge mode the strobe only arms the channel. The pulse then follows the next falling edge on the receive pin, which is synchronized on the selected operation clock. While the channel runs, the word is locked against writes except for its interrupt-source bit.

A parameter removes the trigger and inversion features for a simpler channel variant. On that variant bits 8 and 6 read as 0.

Top module: `sermode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x0020, start_pulse is 0 and xfer_clk_en is 0.
- R2: Bits 13..9, 7, 4 and 3 always read 0 and bit 5 always reads 1. Writing 0xFFFF while idle reads back 0xC167, and writing 0x0000 reads back 0x0020.
- R3: With chan_run at 0, a write stores bits 15, 14, 8, 6, 2, 1 and 0. The new value shows on rd_data in the cycle after the write edge.
- R4: With chan_run at 1, a write changes only bit 0. Bits 15..1 keep their value.
- R5: Bit 15 selects the operation clock. A value of 0 passes ck0_en to op_clk_en, and a value of 1 passes ck1_en.
- R6: When bit 14 is 1, xfer_clk_en follows ext_sck_en and ext_clk_sel is 1.
- R7: When bit 14 is 0 and the channel runs, xfer_clk_en pulses once every (div_ratio+1)*2 operation-clock enables. The count starts from 0 when chan_run rises.
- R8: proto_mode equals bits 2:1, encoded 00 SPI, 01 UART and 10 I2C. irq_src_sel equals bit 0.
- R9: rxd_data is the inverse of rxd_pin only when bit 6 is 1 and proto_mode is 01 (UART). Otherwise rxd_data equals rxd_pin.
- R10: When bit 8 is 0, a start_req on a running channel gives a one-clock start_pulse in the following cycle.
- R11: When bit 8 is 1, start_req only arms the channel. A falling edge on rxd_pin after arming gives start_pulse three clocks after the pin changes, provided the operation clock is enabled every cycle. The armed state then clears, and a falling edge before arming is ignored.
- R12: start_req while chan_run is 0 is ignored. Dropping chan_run clears the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Mode word as read back |
| chan_run | input | 1 | Channel enable flag |
| start_req | input | 1 | Start strobe |
| rxd_pin | input | 1 | Receive-data pin |
| ck0_en | input | 1 | Prescaled clock enable 0 |
| ck1_en | input | 1 | Prescaled clock enable 1 |
| ext_sck_en | input | 1 | External serial-clock enable |
| div_ratio | input | 7 | Divider setting from the channel data register |
| op_clk_en | output | 1 | Selected operation-clock enable |
| xfer_clk_en | output | 1 | Transfer-clock enable |
| ext_clk_sel | output | 1 | Transfer clock taken from the external input |
| proto_mode | output | 2 | Protocol mode |
| irq_src_sel | output | 1 | Interrupt source choice |
| rxd_data | output | 1 | Receive data after optional inversion |
| start_pulse | output | 1 | One-clock transfer-start pulse |

## Verification
The clock-select, mode-field and inversion outputs are combinational, so the bench checks them at the falling edge right after it changes the inputs. A register write is visible one clock after its write edge. A software start is due one clock after the strobe, and an edge start is due three clocks after the pin falls. The bench records the cycle number at which each start pulse is expected in a scoreboard queue. The monitor fails any pulse that is early, late or not expected. Divider output is counted over a window of whole periods that begins on the rising edge of chan_run.

// File: rtl/sermode_pkg.sv
package sermode_pkg;
  localparam int unsigned CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0020;
  localparam logic [CFG_W-1:0] CFG_ONES  = 16'h0020;

  localparam int unsigned B_CLKSEL = 15;
  localparam int unsigned B_XCLK   = 14;
  localparam int unsigned B_TRIG   = 8;
  localparam int unsigned B_RXINV  = 6;
  localparam int unsigned B_IRQ    = 0;

  typedef enum logic [1:0] {
    PMODE_SPI  = 2'b00,
    PMODE_UART = 2'b01,
    PMODE_I2C  = 2'b10,
    PMODE_RSVD = 2'b11
  } proto_mode_e;

  // Bits that accept writes while the channel is idle
  function automatic logic [CFG_W-1:0] idle_wr_mask(input bit has_trig);
    logic [CFG_W-1:0] m;
    m = 16'hC007;
    if (has_trig) m = m | 16'h0140;
    return m;
  endfunction

  // Operation-clock enables per transfer-clock enable
  function automatic logic [16:0] xfer_period(input logic [15:0] ratio);
    return ({1'b0, ratio} + 17'd1) << 1;
  endfunction
endpackage

// File: rtl/sermode_reg.sv
module sermode_reg
  import sermode_pkg::*;
#(
  parameter bit HAS_RX_TRIG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             chan_run,
  output logic [CFG_W-1:0] cfg_q
);
  localparam logic [CFG_W-1:0] WR_MASK = idle_wr_mask(HAS_RX_TRIG);

  logic wr_locked;
  assign wr_locked = wr_en & chan_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_locked) begin
      cfg_q[B_IRQ] <= wr_data[B_IRQ];
    end else if (wr_en) begin
      cfg_q <= (wr_data & WR_MASK) | CFG_ONES;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_run |=> $stable(cfg_q[CFG_W-1:1])); // R4
endmodule

// File: rtl/sermode_clk.sv
module sermode_clk
  import sermode_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_run,
  input  logic             clk_sel,
  input  logic             ext_sel,
  input  logic             ck0_en,
  input  logic             ck1_en,
  input  logic             ext_sck_en,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             op_clk_en,
  output logic             xfer_clk_en
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [16:0]      period;
  logic             at_wrap;
  logic             div_active;
  logic             div_tick;

  assign op_clk_en  = clk_sel ? ck1_en : ck0_en;
  assign period     = xfer_period(16'(div_ratio));
  assign at_wrap    = (17'(cnt_q) == (period - 17'd1));
  assign div_active = chan_run & ~ext_sel;
  assign div_tick   = div_active & op_clk_en & at_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!div_active) begin
      cnt_q <= '0;
    end else if (op_clk_en) begin
      cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign xfer_clk_en = ext_sel ? ext_sck_en : div_tick;

  AST_DIV_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick); // R7
endmodule

// File: rtl/sermode_trig.sv
module sermode_trig #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_run,
  input  logic edge_mode,
  input  logic op_clk_en,
  input  logic start_req,
  input  logic rxd_pin,
  output logic start_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   armed_q;
  logic                   rx_fall;
  logic                   edge_fire;
  logic                   sw_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else if (op_clk_en) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_pin};
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rx_fall   = op_clk_en & hist_q & ~sync_q[SYNC_STAGES-1];
  assign edge_fire = chan_run & edge_mode & armed_q & rx_fall;
  assign sw_fire   = chan_run & ~edge_mode & start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= sw_fire | edge_fire;
      if (!chan_run || !edge_mode) armed_q <= 1'b0;
      else if (edge_fire)          armed_q <= 1'b0;
      else if (start_req)          armed_q <= 1'b1;
    end
  end

  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(chan_run)); // R12
  AST_EDGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && $past(edge_mode)) |-> $past(armed_q)); // R11
  AST_IDLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_run |=> !armed_q); // R12
endmodule

// File: rtl/sermode_ctrl.sv
module sermode_ctrl
  import sermode_pkg::*;
#(
  parameter bit          HAS_RX_TRIG = 1'b1,
  parameter int unsigned DIV_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic             chan_run,
  input  logic             start_req,
  input  logic             rxd_pin,
  input  logic             ck0_en,
  input  logic             ck1_en,
  input  logic             ext_sck_en,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             op_clk_en,
  output logic             xfer_clk_en,
  output logic             ext_clk_sel,
  output logic [1:0]       proto_mode,
  output logic             irq_src_sel,
  output logic             rxd_data,
  output logic             start_pulse
);
  logic [CFG_W-1:0] cfg_q;
  logic             uart_sel;
  logic             rx_inv_on;

  sermode_reg #(.HAS_RX_TRIG(HAS_RX_TRIG)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .chan_run(chan_run), .cfg_q(cfg_q)
  );

  sermode_clk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .chan_run(chan_run),
    .clk_sel(cfg_q[B_CLKSEL]), .ext_sel(cfg_q[B_XCLK]),
    .ck0_en(ck0_en), .ck1_en(ck1_en), .ext_sck_en(ext_sck_en),
    .div_ratio(div_ratio), .op_clk_en(op_clk_en), .xfer_clk_en(xfer_clk_en)
  );

  sermode_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .chan_run(chan_run),
    .edge_mode(cfg_q[B_TRIG]), .op_clk_en(op_clk_en),
    .start_req(start_req), .rxd_pin(rxd_pin), .start_pulse(start_pulse)
  );

  assign rd_data     = cfg_q;
  assign ext_clk_sel = cfg_q[B_XCLK];
  assign proto_mode  = cfg_q[2:1];
  assign irq_src_sel = cfg_q[B_IRQ];
  assign uart_sel    = (proto_mode_e'(cfg_q[2:1]) == PMODE_UART);
  assign rx_inv_on   = cfg_q[B_RXINV] & uart_sel;
  assign rxd_data    = rxd_pin ^ rx_inv_on;

  AST_START_SINGLE_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !$past(start_req)) |-> $past(cfg_q[B_TRIG])); // R10
endmodule

// File: tb/sermode_ctrl_test.sv
`timescale 1ns/1ps
module sermode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic chan_run = 1'b0, start_req = 1'b0, rxd_pin = 1'b1;
  logic ck0_en = 1'b1, ck1_en = 1'b0, ext_sck_en = 1'b0;
  logic [6:0] div_ratio = '0;
  logic op_clk_en, xfer_clk_en, ext_clk_sel, irq_src_sel, rxd_data, start_pulse;
  logic [1:0] proto_mode;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  string phase = "R1";
  int    exp_cyc[$];
  string exp_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sermode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .chan_run(chan_run), .start_req(start_req), .rxd_pin(rxd_pin),
    .ck0_en(ck0_en), .ck1_en(ck1_en), .ext_sck_en(ext_sck_en), .div_ratio(div_ratio),
    .op_clk_en(op_clk_en), .xfer_clk_en(xfer_clk_en), .ext_clk_sel(ext_clk_sel),
    .proto_mode(proto_mode), .irq_src_sel(irq_src_sel), .rxd_data(rxd_data),
    .start_pulse(start_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  // Driver: strobe start, optionally pushing the cycle the pulse is due
  task automatic pulse_req(input bit expect_now, input string tag);
    start_req = 1'b1;
    if (expect_now) begin exp_cyc.push_back(cyc + 1); exp_tag.push_back(tag); end
    step(1);
    start_req = 1'b0;
  endtask

  task automatic fall_rx(input bit expect_fire, input string tag);
    rxd_pin = 1'b0;
    if (expect_fire) begin exp_cyc.push_back(cyc + 3); exp_tag.push_back(tag); end
    step(6);
    rxd_pin = 1'b1;
    step(6);
  endtask

  // Monitor: compare each start pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        check(1'b0, {exp_tag[0], " start pulse missing"}, 0, 1);
        void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end
      if (start_pulse) begin
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
          check(1'b1, exp_tag[0], 1, 1);
          void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
        end else begin
          check(1'b0, {phase, " unexpected start pulse"}, 1, 0);
        end
      end
    end
  end

  task automatic div_window(input int r, input int k);
    int p, seen;
    p = (r + 1) * 2; seen = 0;
    div_ratio = 7'(r); ck0_en = 1'b1;
    chan_run = 1'b1;
    for (int i = 0; i < p * k; i++) begin
      step(1);
      if (xfer_clk_en) seen++;
    end
    check(seen == k, "R7 divided transfer clock count", seen, k);
    chan_run = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check(rd_data == 16'h0020, "R1 reset value", rd_data, 16'h0020);
    check(!start_pulse && !xfer_clk_en, "R1 reset outputs", {start_pulse, xfer_clk_en}, 0);

    phase = "R2";
    write_cfg(16'hFFFF);
    check(rd_data == 16'hC167, "R2 fixed bits after all-ones", rd_data, 16'hC167);
    write_cfg(16'h0000);
    check(rd_data == 16'h0020, "R2 fixed bits after zero", rd_data, 16'h0020);

    phase = "R3";
    write_cfg(16'h4007);
    check(rd_data == 16'h4027, "R3 idle write stored", rd_data, 16'h4027);

    phase = "R4";
    chan_run = 1'b1;
    write_cfg(16'h8100);
    check(rd_data == 16'h4026, "R4 locked write keeps 15:1", rd_data, 16'h4026);
    chan_run = 1'b0;
    step(1);

    phase = "R6";
    ext_sck_en = 1'b1; step(1);
    check(xfer_clk_en && ext_clk_sel, "R6 external clock passes", xfer_clk_en, 1);
    ext_sck_en = 1'b0; ck0_en = 1'b1; step(1);
    check(!xfer_clk_en, "R6 external clock low", xfer_clk_en, 0);

    phase = "R8";
    check(proto_mode == 2'b11 && irq_src_sel == 1'b0, "R8 fields", {proto_mode, irq_src_sel}, 3'b110);
    write_cfg(16'h0005);
    check(proto_mode == 2'b10 && irq_src_sel, "R8 I2C mode and irq", {proto_mode, irq_src_sel}, 3'b101);

    phase = "R5";
    ck0_en = 1'b1; ck1_en = 1'b0; step(1);
    check(op_clk_en == 1'b1, "R5 ck0 selected", op_clk_en, 1);
    write_cfg(16'h8000);
    check(op_clk_en == 1'b0, "R5 ck1 selected low", op_clk_en, 0);
    ck1_en = 1'b1; step(1);
    check(op_clk_en == 1'b1, "R5 ck1 selected high", op_clk_en, 1);
    ck1_en = 1'b0;

    phase = "R9";
    write_cfg(16'h0042);
    rxd_pin = 1'b1; step(1);
    check(rxd_data == 1'b0, "R9 UART inverts", rxd_data, 0);
    write_cfg(16'h0040);
    check(rxd_data == 1'b1, "R9 SPI no inversion", rxd_data, 1);

    phase = "R7";
    write_cfg(16'h0000);
    div_window(0, 5);
    div_window(2, 3);

    phase = "R10";
    write_cfg(16'h0000);
    chan_run = 1'b1; step(1);
    pulse_req(1'b1, "R10 software start");
    step(3);
    pulse_req(1'b1, "R10 second software start");
    step(3);
    chan_run = 1'b0; step(1);

    phase = "R12";
    pulse_req(1'b0, "R12");
    step(3);

    phase = "R11";
    write_cfg(16'h0102);
    chan_run = 1'b1; step(1);
    fall_rx(1'b0, "R11 edge before arm");
    pulse_req(1'b0, "R11");
    step(2);
    fall_rx(1'b1, "R11 edge start");
    fall_rx(1'b0, "R11 second edge after fire");

    phase = "R12";
    pulse_req(1'b0, "R12");
    step(2);
    chan_run = 1'b0; step(2);
    chan_run = 1'b1; step(2);
    fall_rx(1'b0, "R12 disarmed by disable");
    chan_run = 1'b0;
    step(4);
    check(exp_cyc.size() == 0, "R11 scoreboard drained", exp_cyc.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule